// File: doc/BRIEF.md
# Column-Keyed Lane Shuffle Network

This block sits beside a memory controller and rearranges the eight chip-sized words of a 512-bit cache line before the line is written to a multi-chip DRAM rank, and puts them back in order after a read. Word lane `i` of the line is the 64-bit slice destined for chip `i`. The rearrangement is keyed by the low bits of the line's DRAM column index, so neighbouring columns get different permutations. Values a power-of-two stride apart then sit on different chips, and a single command can fetch all of them at once.

The network is a chain of three conditional swap stages. Stage `s` (counting from 0) is driven by column bit `s`. When that bit is 1, the stage exchanges adjacent blocks of `2^s` lanes. Every stage undoes itself and the stages commute, so the net effect is that output lane `i` takes input lane `i XOR col[2:0]`. The same hardware therefore serves for scatter and for gather. A direction input picks which stage order is used, so both paths can be exercised. The result is registered. A valid/ready handshake gives one cycle of latency and holds the output while the consumer stalls.

Top module: `lane_shuffle`

## Requirements
- R1: After reset is released, `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: When `in_col_i[2:0]` is 0, the output line equals the input line in both directions.
- R3: Output lane `i` (bits `64*i+63 : 64*i`) equals input lane `i XOR in_col_i[2:0]`; column bits above bit 2 have no effect on the result.
- R4: Each column bit acts alone as one swap stage: bit 0 exchanges single adjacent lanes (lane 0 with 1), bit 1 exchanges lane pairs (lane 0 with 2), and bit 2 exchanges lane quads (lane 0 with 4).
- R5: With `in_dir_i` = 0 (scatter) and `in_dir_i` = 1 (gather) the permutation is the same, so passing a scatter result back through gather with the same column restores the original line.
- R6: An input accepted on a rising edge (`in_valid_i` and `in_ready_o` both 1) appears on `out_line_o` with `out_valid_o` = 1 right after that edge. Back-to-back inputs are accepted every cycle while `out_ready_i` is 1.
- R7: While `out_valid_o` is 1 and `out_ready_i` is 0, `in_ready_o` is 0, and `out_line_o` and `out_valid_o` hold their values.
- R8: When the output is consumed and no new input is offered, `out_valid_o` falls to 0 after that edge.
- R9: For the eight columns 0..7, the word in lane 0 of each line lands on chip `c` for column `c`, so the eight words occupy eight distinct chips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input line offered |
| in_ready_o | output | 1 | Input line can be accepted |
| in_line_i | input | 512 | Cache line, 8 lanes of 64 bits |
| in_col_i | input | 7 | DRAM column index of the line |
| in_dir_i | input | 1 | 0 = scatter (before write), 1 = gather (after read) |
| out_valid_o | output | 1 | Output line valid |
| out_ready_i | input | 1 | Consumer takes the output line |
| out_line_o | output | 512 | Permuted cache line |

## Verification
Every permuted line is due one rising edge after the edge that accepts it. The bench drives inputs on the falling edge, lets one rising edge pass, and samples `out_line_o` and `out_valid_o` on the following falling edge. For stalls, it checks that the held line is unchanged after each extra rising edge. It then releases `out_ready_i` and expects the waiting line one edge later, and an empty output one edge after that. The expected line comes from the XOR lane rule, applied independently in the bench.

// File: rtl/lane_shuffle_pkg.sv
package lane_shuffle_pkg;
  typedef enum logic {
    DIR_SCATTER = 1'b0,
    DIR_GATHER  = 1'b1
  } shuf_dir_e;
endpackage

// File: rtl/shuf_stage.sv
module shuf_stage #(
  parameter int LANES  = 8,
  parameter int LANE_W = 64,
  parameter int DIST   = 1
) (
  input  logic                    en_i,
  input  logic [LANES*LANE_W-1:0] line_i,
  output logic [LANES*LANE_W-1:0] line_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int SRC = i ^ DIST;
    assign line_o[i*LANE_W +: LANE_W] = en_i ? line_i[SRC*LANE_W +: LANE_W]
                                             : line_i[i*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/shuf_net.sv
module shuf_net
  import lane_shuffle_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int LANE_W = 64,
  parameter int STAGES = $clog2(LANES)
) (
  input  logic [STAGES-1:0]       sel_i,
  input  shuf_dir_e               dir_i,
  input  logic [LANES*LANE_W-1:0] line_i,
  output logic [LANES*LANE_W-1:0] line_o
);
  localparam int LINE_W = LANES * LANE_W;

  logic [LINE_W-1:0] fwd [STAGES+1];
  logic [LINE_W-1:0] rev [STAGES+1];

  assign fwd[0] = line_i;
  assign rev[0] = line_i;

  // scatter chain: smallest block first; gather chain: largest block first
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int RS = STAGES - 1 - s;
    shuf_stage #(.LANES(LANES), .LANE_W(LANE_W), .DIST(1 << s)) u_fwd (
      .en_i  (sel_i[s]),
      .line_i(fwd[s]),
      .line_o(fwd[s+1])
    );
    shuf_stage #(.LANES(LANES), .LANE_W(LANE_W), .DIST(1 << RS)) u_rev (
      .en_i  (sel_i[RS]),
      .line_i(rev[s]),
      .line_o(rev[s+1])
    );
  end

  assign line_o = (dir_i == DIR_GATHER) ? rev[STAGES] : fwd[STAGES];
endmodule

// File: rtl/shuf_pipe.sv
module shuf_pipe #(
  parameter int W = 512
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);
  logic         vld_q;
  logic [W-1:0] dat_q;
  logic         take;

  assign in_ready_o = !vld_q || out_ready_i;
  assign take       = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      if (in_ready_o) vld_q <= in_valid_i;
      if (take)       dat_q <= in_data_i;
    end
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = dat_q;

  AST_ACCEPT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o); // R6
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)); // R7
  AST_DRAIN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !in_valid_i |=> !out_valid_o); // R8
endmodule

// File: rtl/lane_shuffle.sv
module lane_shuffle
  import lane_shuffle_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int LANE_W = 64,
  parameter int COL_W  = 7,
  localparam int LINE_W = LANES * LANE_W,
  localparam int STAGES = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [LINE_W-1:0] in_line_i,
  input  logic [COL_W-1:0]  in_col_i,
  input  logic              in_dir_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [LINE_W-1:0] out_line_o
);
  logic [LINE_W-1:0] perm_line;
  logic [STAGES-1:0] sel;
  shuf_dir_e         dir;

  assign sel = in_col_i[STAGES-1:0];
  assign dir = shuf_dir_e'(in_dir_i);

  if (COL_W > STAGES) begin : g_hi_col
    logic unused_col_hi;
    assign unused_col_hi = ^in_col_i[COL_W-1:STAGES];
  end

  shuf_net #(.LANES(LANES), .LANE_W(LANE_W), .STAGES(STAGES)) u_net (
    .sel_i (sel),
    .dir_i (dir),
    .line_i(in_line_i),
    .line_o(perm_line)
  );

  shuf_pipe #(.W(LINE_W)) u_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_data_i  (perm_line),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_data_o (out_line_o)
  );

  AST_ZERO_COL_IDENTITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && (sel == '0) |=> out_line_o == $past(in_line_i)); // R2
endmodule

// File: tb/tb_lane_shuffle.sv
module tb_lane_shuffle;
  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 8;
  localparam int LANE_W = 64;
  localparam int LINE_W = LANES * LANE_W;
  localparam int COL_W  = 7;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [LINE_W-1:0] in_line = '0;
  logic [COL_W-1:0]  in_col = '0;
  logic              in_dir = 1'b0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [LINE_W-1:0] out_line;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_shuffle #(.LANES(LANES), .LANE_W(LANE_W), .COL_W(COL_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_line_i(in_line), .in_col_i(in_col), .in_dir_i(in_dir),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_line_o(out_line)
  );

  function automatic logic [LINE_W-1:0] expect_line(logic [LINE_W-1:0] l, logic [COL_W-1:0] c);
    logic [LINE_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*LANE_W +: LANE_W] = l[(i ^ int'(c[2:0]))*LANE_W +: LANE_W];
    return r;
  endfunction

  function automatic logic [LINE_W-1:0] rnd_line();
    logic [LINE_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*LANE_W +: LANE_W] = {$urandom(), $urandom()};
    return r;
  endfunction

  task automatic chk_bit(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic chk_line(string req, string what, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive on falling edge, accept on rising edge, sample on next falling edge
  task automatic send(logic [LINE_W-1:0] l, logic [COL_W-1:0] c, logic d,
                      output logic [LINE_W-1:0] res);
    @(negedge clk);
    in_line = l; in_col = c; in_dir = d; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit("R6", "valid one cycle after accept", out_valid, 1'b1);
    res = out_line;
  endtask

  task automatic t_reset();
    chk_bit("R1", "out_valid after reset", out_valid, 1'b0);
    chk_bit("R1", "in_ready after reset", in_ready, 1'b1);
  endtask

  task automatic t_identity();
    logic [LINE_W-1:0] l, r;
    l = rnd_line();
    send(l, 7'd0, 1'b0, r); chk_line("R2", "col 0 scatter", r, l);
    send(l, 7'd0, 1'b1, r); chk_line("R2", "col 0 gather", r, l);
    send(l, 7'd8, 1'b0, r); chk_line("R3", "col 8 high bit ignored", r, l);
  endtask

  task automatic t_single_bits();
    logic [LINE_W-1:0] l, r;
    l = rnd_line();
    send(l, 7'd1, 1'b0, r);
    chk_line("R4", "bit0 lane0 from lane1", {448'd0, r[63:0]}, {448'd0, l[127:64]});
    chk_line("R4", "bit0 whole line", r, expect_line(l, 7'd1));
    send(l, 7'd2, 1'b0, r);
    chk_line("R4", "bit1 lane0 from lane2", {448'd0, r[63:0]}, {448'd0, l[191:128]});
    send(l, 7'd4, 1'b0, r);
    chk_line("R4", "bit2 lane0 from lane4", {448'd0, r[63:0]}, {448'd0, l[319:256]});
    chk_line("R4", "bit2 whole line", r, expect_line(l, 7'd4));
  endtask

  task automatic t_all_cols();
    logic [LINE_W-1:0] l, r;
    for (int c = 0; c < 8; c++) begin
      for (int d = 0; d < 2; d++) begin
        l = rnd_line();
        send(l, COL_W'(c), d[0], r);
        chk_line("R3", $sformatf("col %0d dir %0d", c, d), r, expect_line(l, COL_W'(c)));
      end
    end
  endtask

  task automatic t_high_bits();
    logic [LINE_W-1:0] l, r;
    for (int k = 1; k < 16; k += 5) begin
      l = rnd_line();
      send(l, COL_W'((k << 3) | 5), 1'b0, r);
      chk_line("R3", $sformatf("col high %0d low 5", k), r, expect_line(l, 7'd5));
    end
  endtask

  task automatic t_round_trip();
    logic [LINE_W-1:0] l, s, g;
    for (int c = 0; c < 8; c++) begin
      l = rnd_line();
      send(l, COL_W'(c + 16), 1'b0, s);
      send(s, COL_W'(c + 16), 1'b1, g);
      chk_line("R5", $sformatf("scatter then gather col %0d", c), g, l);
    end
  endtask

  task automatic t_back_to_back();
    logic [LINE_W-1:0] a, b;
    a = rnd_line(); b = rnd_line();
    @(negedge clk);
    in_line = a; in_col = 7'd3; in_dir = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk_line("R6", "first of pair", out_line, expect_line(a, 7'd3));
    in_line = b; in_col = 7'd6;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit("R6", "second of pair valid", out_valid, 1'b1);
    chk_line("R6", "second of pair", out_line, expect_line(b, 7'd6));
  endtask

  task automatic t_stall();
    logic [LINE_W-1:0] a, b;
    a = rnd_line(); b = rnd_line();
    @(negedge clk);
    out_ready = 1'b0;
    in_line = a; in_col = 7'd2; in_dir = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk_bit("R7", "in_ready low while stalled", in_ready, 1'b0);
    in_line = b; in_col = 7'd7;
    for (int n = 0; n < 3; n++) begin
      @(posedge clk);
      @(negedge clk);
      chk_bit("R7", "valid held", out_valid, 1'b1);
      chk_line("R7", "line held", out_line, expect_line(a, 7'd2));
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk_line("R7", "waiting line taken after release", out_line, expect_line(b, 7'd7));
    @(posedge clk);
    @(negedge clk);
    chk_bit("R8", "empty after drain", out_valid, 1'b0);
    chk_bit("R8", "ready when empty", in_ready, 1'b1);
  endtask

  task automatic t_spread();
    logic [LINE_W-1:0] l, r;
    logic [7:0] hit;
    hit = '0;
    for (int c = 0; c < 8; c++) begin
      l = '0;
      l[63:0] = 64'hC0DE_0000_0000_0000 | 64'(c);
      send(l, COL_W'(c), 1'b0, r);
      chk_line("R9", $sformatf("col %0d word on chip %0d", c, c),
               {448'd0, r[c*LANE_W +: LANE_W]}, {448'd0, l[63:0]});
      for (int i = 0; i < LANES; i++) if (r[i*LANE_W +: LANE_W] != 64'd0) hit[i] = 1'b1;
    end
    checks++;
    if (hit !== 8'hFF) begin
      errors++;
      $display("FAIL R9 chips covered: actual=%h expected=ff", hit);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_identity();
    t_single_bits();
    t_all_cols();
    t_high_bits();
    t_round_trip();
    t_back_to_back();
    t_stall();
    t_spread();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule